// File: doc/BRIEF.md
# Bus Configuration Register File

This block holds the configuration-space registers a host-bridge bus interface shows to configuration software. Accesses are 32-bit and aligned. The access selects a dword through its index and picks byte lanes with four byte enables, so each byte of the 256-byte space has its own position. The block returns read data combinationally from the current index. A write takes effect at the clock edge on the enabled lanes only.

The space contains several kinds of field:
- A sticky parity-detected status flag. It is set by three hardware conditions that must hold together, and software clears it by writing one.
- A fast back-to-back capable bit that is always set.
- Fixed revision and class identity fields.
- A cache line size byte that is always zero.
- A five-bit latency limit.
- A byte of target mode controls.

The latency limit and the mode controls leave the block as plain outputs for the timer and target logic. Every other index reads zero and ignores writes.

Top module: `cfg_regfile`

## Requirements
- R1: The parity flag (byte 07h bit 0, read as bit 24 of dword index 1) is 1 in the cycle after one in which `perr_evt`, `bus_master` and `perr_resp_en` are all 1. The flag does not become 1 when any one of the three is 0.
- R2: A write to dword index 1 with `cfg_be[3]`=1 and `cfg_wdata[24]`=1 clears the parity flag at the next edge. A write with `cfg_wdata[24]`=0, or with `cfg_be[3]`=0, leaves the flag unchanged.
- R3: When a set condition and a clearing write fall in the same cycle, the flag is 1 afterwards.
- R4: Dword index 1 reads 00h in bytes 04h and 05h, 80h in byte 06h (the fast back-to-back bit), and zero in bits 7:1 of byte 07h. Writes do not change these values.
- R5: Byte 08h reads the `REV_ID` parameter, and bytes 09h, 0Ah and 0Bh read `CLASS_CODE` bits 7:0, 15:8 and 23:16. The default class code is 060000h. Writes do not change any of these bytes.
- R6: Byte 0Ch (cache line size) reads 00h, even after a write to it.
- R7: Byte 0Dh bits 4:0 hold the latency limit, which drives `lat_limit`. Those bits are written only when `cfg_be[1]`=1 at dword index 3. Bits 7:5 read 0, and bytes 0Eh and 0Fh read 0.
- R8: Byte 40h (dword index 16, lane 0) holds the mode controls in bits 6:1. The bits are assigned as follows: bit 6 single write, bit 5 single read, bit 4 retry while write data is pending, bit 3 target write buffer enable, bit 2 line read enable, bit 1 burst write enable. Each bit drives its own `ctl_*` output. Bits 7 and 0 read 0, and the byte is written only when `cfg_be[0]`=1.
- R9: Every dword index other than 1, 2, 3 and 16 reads all zero. A write to such an index changes no output and no read value.
- R10: While `rst` is 1 and after it is released, the parity flag, the latency limit and all mode controls are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the current access |
| cfg_dw | input | 6 | Dword index (byte index bits 7:2) |
| cfg_be | input | 4 | Byte-lane enables, bit n selects byte n of the dword |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_dw` |
| perr_evt | input | 1 | Parity error driven or observed this cycle |
| bus_master | input | 1 | This block owned the cycle as bus master |
| perr_resp_en | input | 1 | Parity response enable from the command register |
| lat_limit | output | 5 | Latency limit value |
| ctl_wr_single | output | 1 | Single write transfer mode |
| ctl_rd_single | output | 1 | Single read transfer mode |
| ctl_retry_pending | output | 1 | Retry while write data is pending |
| ctl_tgt_wbuf_en | output | 1 | Target write buffer enable |
| ctl_line_read_en | output | 1 | Line read enable |
| ctl_burst_wr_en | output | 1 | Burst write enable |

## Verification
The bench builds the block with `REV_ID` = A7h and the default `CLASS_CODE` of 060000h. The non-zero revision makes a lane swap or a missing byte in the identity dword show up as a wrong value, and a zero revision would hide both. The bench sweeps all 64 dword indexes with full-lane writes of non-zero data, then reads each one back. That pass reaches every undefined index and every masked reserved bit. It also drives all eight combinations of the three parity conditions, and the set-and-clear collision.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int CFG_ADDR_W = 8;
    localparam int DW_IDX_W   = CFG_ADDR_W - 2;
    localparam int LANES      = 4;
    localparam int DATA_W     = LANES * 8;
    localparam int LAT_W      = 5;
    localparam int CTL_W      = 6;

    // byte positions that software relies on
    localparam logic [CFG_ADDR_W-1:0] B_STAT_LO  = 8'h06;
    localparam logic [CFG_ADDR_W-1:0] B_STAT_HI  = 8'h07;
    localparam logic [CFG_ADDR_W-1:0] B_REV      = 8'h08;
    localparam logic [CFG_ADDR_W-1:0] B_CLASS0   = 8'h09;
    localparam logic [CFG_ADDR_W-1:0] B_CLASS1   = 8'h0A;
    localparam logic [CFG_ADDR_W-1:0] B_CLASS2   = 8'h0B;
    localparam logic [CFG_ADDR_W-1:0] B_LATENCY  = 8'h0D;
    localparam logic [CFG_ADDR_W-1:0] B_MODE     = 8'h40;

    localparam logic [7:0] FAST_B2B_BYTE = 8'h80;

    typedef struct packed {
        logic perr_seen;
        logic is_master;
        logic resp_en;
    } perr_evt_t;

    typedef struct packed {
        logic wr_single;
        logic rd_single;
        logic retry_pending;
        logic tgt_wbuf_en;
        logic line_read_en;
        logic burst_wr_en;
    } mode_ctl_t;

    typedef struct packed {
        logic                wr;
        logic [DW_IDX_W-1:0] dw;
        logic [LANES-1:0]    be;
        logic [DATA_W-1:0]   data;
    } cfg_acc_t;

    // true when the access writes the byte at the given byte index
    function automatic logic byte_written(cfg_acc_t a, logic [CFG_ADDR_W-1:0] bidx);
        return a.wr && (a.dw == bidx[CFG_ADDR_W-1:2]) && a.be[bidx[1:0]];
    endfunction

    function automatic logic [7:0] byte_of(cfg_acc_t a, logic [CFG_ADDR_W-1:0] bidx);
        return a.data[bidx[1:0]*8 +: 8];
    endfunction

    function automatic logic evt_fires(perr_evt_t e);
        return e.perr_seen && e.is_master && e.resp_en;
    endfunction

endpackage

// File: rtl/cfg_status_flag.sv
module cfg_status_flag
    import cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  perr_evt_t evt,
    input  cfg_acc_t  acc,
    output logic      flag
);
    logic set_now;
    logic clr_now;
    logic [7:0] hi_byte;

    always_comb begin
        hi_byte = byte_of(acc, B_STAT_HI);
        set_now = evt_fires(evt);
        clr_now = byte_written(acc, B_STAT_HI) && hi_byte[0];
    end

    // set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_now)
            flag <= 1'b1;
        else if (clr_now)
            flag <= 1'b0;
    end
endmodule

// File: rtl/cfg_wr_regs.sv
module cfg_wr_regs
    import cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_acc_t         acc,
    output logic [LAT_W-1:0] lat,
    output mode_ctl_t        mode
);
    logic [7:0] lat_byte;
    logic [7:0] mode_byte;

    always_comb begin
        lat_byte  = byte_of(acc, B_LATENCY);
        mode_byte = byte_of(acc, B_MODE);
    end

    always_ff @(posedge clk) begin
        if (rst)
            lat <= '0;
        else if (byte_written(acc, B_LATENCY))
            lat <= lat_byte[LAT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= '0;
        else if (byte_written(acc, B_MODE))
            mode <= mode_ctl_t'(mode_byte[CTL_W:1]);
    end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
    import cfg_pkg::*;
#(
    parameter logic [7:0]  REV_ID     = 8'h00,
    parameter logic [23:0] CLASS_CODE = 24'h060000
) (
    input  logic [DW_IDX_W-1:0] dw,
    input  logic                flag,
    input  logic [LAT_W-1:0]    lat,
    input  mode_ctl_t           mode,
    output logic [DATA_W-1:0]   rdata
);
    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [CFG_ADDR_W-1:0] bidx;
        logic [7:0]            b;
        always_comb begin
            bidx = {dw, 2'(L)};
            case (bidx)
                B_STAT_LO: b = FAST_B2B_BYTE;
                B_STAT_HI: b = {7'b0, flag};
                B_REV:     b = REV_ID;
                B_CLASS0:  b = CLASS_CODE[7:0];
                B_CLASS1:  b = CLASS_CODE[15:8];
                B_CLASS2:  b = CLASS_CODE[23:16];
                B_LATENCY: b = {{(8-LAT_W){1'b0}}, lat};
                B_MODE:    b = {1'b0, mode, 1'b0};
                default:   b = 8'h00;
            endcase
        end
        assign rdata[L*8 +: 8] = b;
    end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter logic [7:0]  REV_ID     = 8'h00,
    parameter logic [23:0] CLASS_CODE = 24'h060000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [5:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        perr_evt,
    input  logic        bus_master,
    input  logic        perr_resp_en,
    output logic [4:0]  lat_limit,
    output logic        ctl_wr_single,
    output logic        ctl_rd_single,
    output logic        ctl_retry_pending,
    output logic        ctl_tgt_wbuf_en,
    output logic        ctl_line_read_en,
    output logic        ctl_burst_wr_en
);
    cfg_acc_t  acc;
    perr_evt_t evt;
    mode_ctl_t mode;
    logic      dpd_flag;

    assign acc = '{wr: cfg_wr_en, dw: cfg_dw, be: cfg_be, data: cfg_wdata};
    assign evt = '{perr_seen: perr_evt, is_master: bus_master, resp_en: perr_resp_en};

    cfg_status_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .acc  (acc),
        .flag (dpd_flag)
    );

    cfg_wr_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .acc  (acc),
        .lat  (lat_limit),
        .mode (mode)
    );

    cfg_rd_mux #(
        .REV_ID     (REV_ID),
        .CLASS_CODE (CLASS_CODE)
    ) u_rd (
        .dw    (cfg_dw),
        .flag  (dpd_flag),
        .lat   (lat_limit),
        .mode  (mode),
        .rdata (cfg_rdata)
    );

    assign ctl_wr_single     = mode.wr_single;
    assign ctl_rd_single     = mode.rd_single;
    assign ctl_retry_pending = mode.retry_pending;
    assign ctl_tgt_wbuf_en   = mode.tgt_wbuf_en;
    assign ctl_line_read_en  = mode.line_read_en;
    assign ctl_burst_wr_en   = mode.burst_wr_en;
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [5:0]  dw,
    input logic [3:0]  be,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        ev_perr,
    input logic        ev_master,
    input logic        ev_resp,
    input logic        flag,
    input logic [4:0]  lat,
    input logic [5:0]  mode
);
    logic set_c;
    logic clr_c;
    assign set_c = ev_perr && ev_master && ev_resp;
    assign clr_c = wr_en && dw == 6'd1 && be[3] && wdata[24];

    a_r1_sets: assert property (@(posedge clk) disable iff (rst) set_c |=> flag);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!flag && !set_c) |=> !flag);
    a_r2_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_c && !set_c) |=> !flag);
    a_r2_holds: assert property (@(posedge clk) disable iff (rst)
        (!clr_c && !set_c) |=> $stable(flag));
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_c && set_c) |=> flag);
    a_r4_fixed_status: assert property (@(posedge clk) disable iff (rst)
        (dw == 6'd1) |-> (rdata[23:0] == 24'h800000 && rdata[31:25] == 7'd0));
    a_r7_lat_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dw == 6'd3 && be[1]) |=> $stable(lat));
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dw == 6'd16 && be[0]) |=> $stable(mode));
    a_r9_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (dw != 6'd1 && dw != 6'd2 && dw != 6'd3 && dw != 6'd16) |-> rdata == 32'd0);
endmodule

bind cfg_regfile cfg_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr_en),
    .dw        (cfg_dw),
    .be        (cfg_be),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .ev_perr   (perr_evt),
    .ev_master (bus_master),
    .ev_resp   (perr_resp_en),
    .flag      (dpd_flag),
    .lat       (lat_limit),
    .mode      ({ctl_wr_single, ctl_rd_single, ctl_retry_pending,
                 ctl_tgt_wbuf_en, ctl_line_read_en, ctl_burst_wr_en})
);

// File: tb/cfg_regfile_bench.sv
`timescale 1ns/1ps
module cfg_regfile_bench;
    localparam logic [7:0]  REV  = 8'hA7;
    localparam logic [23:0] CLS  = 24'h060000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  dw = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pe = 1'b0, mst = 1'b0, ren = 1'b0;
    logic [4:0]  lat;
    logic        c_ws, c_rs, c_rp, c_wb, c_lr, c_bw;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    bit       m_flag = 0;
    bit [4:0] m_lat = 0;
    bit [5:0] m_mode = 0;

    always #2.5 clk = ~clk;

    cfg_regfile #(.REV_ID(REV), .CLASS_CODE(CLS)) u_cfg_regfile (
        .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_dw(dw), .cfg_be(be),
        .cfg_wdata(wdata), .cfg_rdata(rdata), .perr_evt(pe), .bus_master(mst),
        .perr_resp_en(ren), .lat_limit(lat), .ctl_wr_single(c_ws),
        .ctl_rd_single(c_rs), .ctl_retry_pending(c_rp), .ctl_tgt_wbuf_en(c_wb),
        .ctl_line_read_en(c_lr), .ctl_burst_wr_en(c_bw)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_flag = 0; m_lat = 0; m_mode = 0;
        end else begin
            if (pe && mst && ren) m_flag = 1;
            else if (wr_en && dw == 1 && be[3] && wdata[24]) m_flag = 0;
            if (wr_en && dw == 3 && be[1]) m_lat = wdata[12:8];
            if (wr_en && dw == 16 && be[0]) m_mode = wdata[6:1];
        end
    end

    function automatic logic [31:0] exp_rd(logic [5:0] d);
        case (d)
            6'd1:    return {7'd0, m_flag, 8'h80, 16'h0000};
            6'd2:    return {CLS, REV};
            6'd3:    return {16'h0000, 3'b000, m_lat, 8'h00};
            6'd16:   return {24'h0, 1'b0, m_mode, 1'b0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(logic [5:0] d);
        case (d)
            6'd1:    return "R4";
            6'd2:    return "R5";
            6'd3:    return "R7";
            6'd16:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check(req_of(dw), rdata, exp_rd(dw));
        check("R7", {27'd0, lat}, {27'd0, m_lat});
        check("R8", {26'd0, c_ws, c_rs, c_rp, c_wb, c_lr, c_bw}, {26'd0, m_mode});
    endtask

    task automatic idle(logic [5:0] d);
        wr_en = 0; dw = d; be = 4'h0; wdata = '0; pe = 0; mst = 0; ren = 0;
        tick();
    endtask

    task automatic wr(logic [5:0] d, logic [3:0] b, logic [31:0] v);
        wr_en = 1; dw = d; be = b; wdata = v;
        tick();
        wr_en = 0; be = 4'h0;
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
        end
    end

    initial begin
        @(negedge clk);
        tick();
        // R10: state during reset and after release
        check("R10", {26'd0, c_ws, c_rs, c_rp, c_wb, c_lr, c_bw, 1'b0} | {27'd0, lat}, 32'd0);
        rst = 0;
        idle(6'd1);
        check("R10", rdata, 32'h0080_0000);
        idle(6'd2);
        check("R5", rdata, 32'h0600_00A7);
        idle(6'd3);
        check("R6", rdata & 32'h0000_00FF, 32'd0);

        // R1: the eight event combinations
        for (int k = 0; k < 8; k++) begin
            wr(6'd1, 4'h8, 32'h0100_0000);
            pe = k[0]; mst = k[1]; ren = k[2];
            dw = 6'd1;
            tick();
            pe = 0; mst = 0; ren = 0;
            tick();
            check("R1", {31'd0, rdata[24]}, (k == 7) ? 32'd1 : 32'd0);
        end

        // R2: ineffective clears, then effective clear
        wr(6'd1, 4'h7, 32'hFFFF_FFFF);
        check("R2", {31'd0, rdata[24]}, 32'd1);
        wr(6'd1, 4'hF, 32'hFEFF_FFFF);
        check("R2", {31'd0, rdata[24]}, 32'd1);
        check("R4", rdata, 32'h0180_0000);
        wr(6'd1, 4'hF, 32'h0100_0000);
        check("R2", {31'd0, rdata[24]}, 32'd0);

        // R3: set and clear together
        pe = 1; mst = 1; ren = 1;
        wr(6'd1, 4'h8, 32'h0100_0000);
        pe = 0; mst = 0; ren = 0;
        check("R3", {31'd0, rdata[24]}, 32'd1);

        // R7: latency lanes
        wr(6'd3, 4'hD, 32'hFFFF_FFFF);
        check("R7", {27'd0, lat}, 32'd0);
        wr(6'd3, 4'h2, 32'hFFFF_F5FF);
        check("R7", {27'd0, lat}, 32'd21);
        check("R7", rdata, 32'h0000_1500);
        check("R6", rdata & 32'h0000_00FF, 32'd0);

        // R8: each mode bit
        for (int k = 1; k <= 6; k++) begin
            wr(6'd16, 4'h1, 32'hFFFF_FF00 | (32'd1 << k));
            check("R8", {26'd0, c_ws, c_rs, c_rp, c_wb, c_lr, c_bw}, 32'd1 << (k - 1));
        end
        wr(6'd16, 4'hE, 32'hFFFF_FFFF);
        check("R8", rdata, 32'h0000_0040);
        wr(6'd16, 4'h1, 32'hFFFF_FFFF);
        check("R8", rdata, 32'h0000_007E);

        // R9, R4, R5, R6: sweep writes then reads
        for (int d = 0; d < 64; d++) wr(6'(d), 4'hF, 32'hA5C3_96F0 ^ (32'(d) * 32'h0101_0101));
        for (int d = 0; d < 64; d++) idle(6'(d));
        idle(6'd2);
        check("R5", rdata, 32'h0600_00A7);

        // R10: reset again
        rst = 1;
        idle(6'd3);
        rst = 0;
        idle(6'd16);
        check("R10", rdata | {27'd0, lat}, 32'd0);

        done = 1;
        report();
    end
endmodule